// File: doc/BRIEF.md
# Two-Wire Slave for a Dual Digital Potentiometer Register Bank

This block is the serial front end of a two-channel, 256-step digital potentiometer. It watches raw clock and data lines of a two-wire bus and recognises START and STOP events. It answers only when the first byte after a START carries the fixed device prefix and the four strap-pin bits. The second byte is an instruction that chooses an operation, a register and a potentiometer. A third byte then carries the value to write, or the slave returns register contents one byte at a time.

Each potentiometer has one wiper register, which takes a new value at once. It also has four data registers, which model non-volatile storage. A write to a data register is held until the master ends the transfer with STOP. At that point the value is stored and a programming interval of fixed length begins. During that interval the slave stays off the bus entirely.

Top module: `dpot_bus_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), `busy_o` is 0, every wiper and every data register reads 0.
- R2: The first byte after a START is acknowledged only if it equals {4'b0101, `dev_addr_i`}, with the prefix in bits 7:4. On any other value the slave acknowledges neither that byte nor any later one until the next START.
- R3: The instruction byte is laid out as opcode in bits 7:4, register select in bits 3:2 and pot select in bits 1:0. The opcodes are 1011 (write wiper), 1100 (write data register), 1010 (read wiper) and 1001 (read data register). An instruction with any other opcode, or with a pot select of NUM_POTS or above, is not acknowledged, and the slave then ignores the bus until the next START.
- R4: After a write-wiper instruction, the data byte is acknowledged and the selected wiper output takes that value during the acknowledge clock. `busy_o` stays 0.
- R5: After a write-data-register instruction, the data byte is acknowledged and held. A STOP stores it in the selected data register and raises `busy_o` on the clock after STOP is detected, for exactly PROG_CYCLES clocks.
- R6: While `busy_o` is 1, the slave never drives SDA, and no wiper or register changes.
- R7: A START or a STOP at any point ends the current transfer. A held data-register write that meets a START before its STOP is discarded, and a partly received byte changes nothing. After a STOP, SDA is released.
- R8: A read instruction is followed by the selected register's value, sent MSB first. The slave releases SDA on the ninth clock. If the master acknowledges, the same value is sent again. If it does not, SDA stays released (reads as 0xFF) until the next START or STOP.
- R9: In a write, every byte after the data byte is not acknowledged, and the register keeps the first data byte.
- R10: SDA is open drain: the block only asserts `sda_oe_o` (pull low) or releases it, and it asserts it only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired value) |
| dev_addr_i | input | 4 | Strap bits that form the low half of the device address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High during the programming interval |
| wiper_o | output | NUM_POTS*8 | Wiper values, pot 0 in the low byte |

## Verification
The bench aims at transfers that must leave no trace. It uses addresses with a wrong prefix or wrong strap bits, unknown opcodes, and a pot index past the last potentiometer. A design that compared too few address bits or decoded too loosely would acknowledge these and corrupt a register. It also sends a data-register write that is cut short by a repeated START. A slave that stored the value at the acknowledge rather than at STOP would store it, and would also raise busy. During programming it tries to access the slave and counts the busy cycles, which exposes a slave that answers while busy or a timer that is off by one. On reads it checks a repeated byte after a master acknowledge, and a released line after a master not-acknowledge. A slave that kept driving after a not-acknowledge would pull bits low.

// File: rtl/dpot_pkg.sv
// Shared constants and types for the two-wire potentiometer slave.
// Assumes an 8-bit bus byte and a 2-bit register and pot select field.
package dpot_pkg;
    localparam int SEL_W = 2;
    localparam logic [3:0] DEV_PREFIX   = 4'b0101;
    localparam logic [3:0] OP_RD_DATA   = 4'b1001;
    localparam logic [3:0] OP_WR_DATA   = 4'b1100;
    localparam logic [3:0] OP_RD_WIPER  = 4'b1010;
    localparam logic [3:0] OP_WR_WIPER  = 4'b1011;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_SEND, ST_SKIP
    } bus_state_t;

    typedef struct packed {
        logic [3:0]       opcode;
        logic [SEL_W-1:0] rsel;
        logic [SEL_W-1:0] psel;
    } instr_t;
endpackage

// File: rtl/twb_line_sync.sv
// Synchronises raw SCL/SDA and derives single-cycle bus events.
// Assumes the system clock is several times faster than SCL; lines reset high (idle bus).
module twb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_prev;
    logic sda_prev;

    // Shift both lines through the synchroniser and keep last synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Edge and condition decode on the synchronised lines.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/dpot_prog_timer.sv
// Counts the programming interval of a data-register store.
// Assumes start only arrives while idle; busy lasts exactly PROG_CYCLES clocks.
module dpot_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] remain;

    // Load on start, count down while busy, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(PROG_CYCLES - 1);
        end
    end
endmodule

// File: rtl/dpot_regbank.sv
// Wiper and data registers for all potentiometers, with one read port.
// Assumes writes arrive as single-cycle enables; selects beyond the array read 0.
module dpot_regbank
    import dpot_pkg::*;
#(
    parameter int NUM_POTS = 2,
    parameter int BYTE_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wiper_we,
    input  logic                       data_we,
    input  logic [SEL_W-1:0]           pot_sel,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic                       rd_wiper,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_POTS*BYTE_W-1:0] wiper_flat
);
    localparam int NUM_DREGS = 1 << SEL_W;
    logic [NUM_POTS*NUM_DREGS*BYTE_W-1:0] data_flat;

    for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
        logic [BYTE_W-1:0] wiper_q;
        // Wiper register of this pot, updated immediately on write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  wiper_q <= '0;
            else if (wiper_we && pot_sel == SEL_W'(p))   wiper_q <= wdata;
        end
        assign wiper_flat[p*BYTE_W +: BYTE_W] = wiper_q;

        for (genvar r = 0; r < NUM_DREGS; r++) begin : g_reg
            logic [BYTE_W-1:0] val_q;
            // One stored data register of this pot.
            always_ff @(posedge clk) begin
                if (!rst_n) val_q <= '0;
                else if (data_we && pot_sel == SEL_W'(p) && reg_sel == SEL_W'(r)) val_q <= wdata;
            end
            assign data_flat[(p*NUM_DREGS+r)*BYTE_W +: BYTE_W] = val_q;
        end
    end

    // Read multiplexer over wipers or data registers.
    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_POTS; p++) begin
            if (pot_sel == SEL_W'(p)) begin
                if (rd_wiper) rdata = wiper_flat[p*BYTE_W +: BYTE_W];
                else begin
                    for (int r = 0; r < NUM_DREGS; r++)
                        if (reg_sel == SEL_W'(r))
                            rdata = data_flat[(p*NUM_DREGS+r)*BYTE_W +: BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/dpot_bus_slave.sv
// Two-wire slave in front of a dual potentiometer register bank.
// Decodes address, instruction and data bytes, serves reads, and locks itself
// off the bus while a data-register store is programming.
// Assumes clk runs at least 8x faster than SCL; SDA only ever pulled low.
module dpot_bus_slave
    import dpot_pkg::*;
#(
    parameter int NUM_POTS    = 2,
    parameter int PROG_CYCLES = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [3:0]            dev_addr_i,
    output logic                  sda_oe_o,
    output logic                  busy_o,
    output logic [NUM_POTS*8-1:0] wiper_o
);
    localparam int BYTE_W = 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] pend_val;
    logic [BYTE_W-1:0] rd_val;
    logic [BYTE_W-1:0] wdata;
    instr_t            instr_q;
    logic ack_drv, tx_on, mack, pend_valid;
    logic byte_ok, evt_ok, wiper_we, data_we, is_read;

    twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    dpot_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(data_we), .busy(busy_o)
    );

    dpot_regbank #(.NUM_POTS(NUM_POTS), .BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wiper_we(wiper_we), .data_we(data_we),
        .pot_sel(instr_q.psel), .reg_sel(instr_q.rsel), .wdata(wdata),
        .rd_wiper(instr_q.opcode == OP_RD_WIPER), .rdata(rd_val), .wiper_flat(wiper_o)
    );

    // Decide whether the byte just received deserves an acknowledge.
    always_comb begin
        instr_t cand;
        cand = instr_t'(shreg);
        unique case (state)
            ST_ADDR:  byte_ok = (shreg == {DEV_PREFIX, dev_addr_i});
            ST_INSTR: byte_ok = (cand.opcode inside {OP_RD_DATA, OP_WR_DATA, OP_RD_WIPER, OP_WR_WIPER})
                                && (int'(cand.psel) < NUM_POTS);
            ST_DATA:  byte_ok = 1'b1;
            default:  byte_ok = 1'b0;
        endcase
    end

    // Register-bank strobes: wiper at data acknowledge, data register at STOP.
    always_comb begin
        evt_ok   = !busy_o && !start_det && !stop_det;
        is_read  = (instr_q.opcode == OP_RD_DATA) || (instr_q.opcode == OP_RD_WIPER);
        wiper_we = evt_ok && state == ST_DATA && scl_fall && bit_cnt == 4'd8 && !ack_drv
                   && instr_q.opcode == OP_WR_WIPER;
        data_we  = stop_det && pend_valid && !busy_o;
        wdata    = data_we ? pend_val : shreg;
    end

    // Bus state machine: byte reception, acknowledge, transmit and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; instr_q <= '0;
            ack_drv <= 1'b0; tx_on <= 1'b0; mack <= 1'b0;
            pend_valid <= 1'b0; pend_val <= '0;
        end else if (busy_o || stop_det) begin
            state <= ST_IDLE; ack_drv <= 1'b0; tx_on <= 1'b0; pend_valid <= 1'b0;
        end else if (start_det) begin
            state <= ST_ADDR; bit_cnt <= '0; ack_drv <= 1'b0; tx_on <= 1'b0; pend_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_INSTR, ST_DATA: begin
                    if (scl_rise && bit_cnt < 4'd8) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        if (!ack_drv) begin
                            if (byte_ok) begin
                                ack_drv <= 1'b1;
                                if (state == ST_INSTR) instr_q <= instr_t'(shreg);
                                if (state == ST_DATA && instr_q.opcode == OP_WR_DATA) begin
                                    pend_valid <= 1'b1;
                                    pend_val   <= shreg;
                                end
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else begin
                            ack_drv <= 1'b0;
                            bit_cnt <= '0;
                            if (state == ST_ADDR) state <= ST_INSTR;
                            else if (state == ST_INSTR && is_read) begin
                                state <= ST_SEND; tx_on <= 1'b1; shreg <= rd_val;
                            end else if (state == ST_INSTR) state <= ST_DATA;
                            else state <= ST_SKIP;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        if (bit_cnt < 4'd8) bit_cnt <= bit_cnt + 1'b1;
                        else if (bit_cnt == 4'd8) begin
                            mack <= !sda_s; bit_cnt <= 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) shreg <= {shreg[BYTE_W-2:0], 1'b1};
                        else if (bit_cnt == 4'd8) tx_on <= 1'b0;
                        else if (bit_cnt == 4'd9) begin
                            if (mack) begin
                                tx_on <= 1'b1; shreg <= rd_val; bit_cnt <= '0;
                            end else state <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = ack_drv | (tx_on & ~shreg[BYTE_W-1]);
endmodule

// File: rtl/dpot_bus_slave_chk.sv
// Property checker for dpot_bus_slave, attached by bind.
// Assumes it sees the synchronised SCL and STOP event of the slave.
module dpot_bus_slave_chk #(
    parameter int NUM_POTS    = 2,
    parameter int PROG_CYCLES = 1000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  stop_det,
    input logic                  sda_oe_o,
    input logic                  busy_o,
    input logic [NUM_POTS*8-1:0] wiper_o
);
    int busy_run;

    // Length of the current busy run, used instead of a deep $past.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_run <= 0;
        else if (busy_o) busy_run <= busy_run + 1;
        else             busy_run <= 0;
    end

    p_busy_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> busy_run < PROG_CYCLES);
    p_busy_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_run == PROG_CYCLES);
    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);
    p_wiper_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(wiper_o));
    p_release_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);
endmodule

bind dpot_bus_slave dpot_bus_slave_chk #(.NUM_POTS(NUM_POTS), .PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe_o(sda_oe_o), .busy_o(busy_o), .wiper_o(wiper_o)
);

// File: tb/dpot_bus_slave_test.sv
// Bench: drives the two-wire bus behaviourally and compares against a model.
module dpot_bus_slave_test;
    localparam int NP   = 2;
    localparam int PROG = 600;
    localparam int Q    = 8;
    localparam logic [3:0] STRAP = 4'b1010;
    localparam logic [7:0] ADR   = {4'b0101, STRAP};

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
    logic sda_oe, busy;
    logic [NP*8-1:0] wiper;
    logic sda_line;
    assign sda_line = sda_drv & ~sda_oe;

    int checks = 0, errors = 0;
    int busy_cycles = 0;
    bit mon_en = 1'b0, busy_win = 1'b0;
    logic [7:0] m_wiper [NP];
    int scl_hi = 0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    dpot_bus_slave #(.NUM_POTS(NP), .PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .dev_addr_i(STRAP),
        .sda_oe_o(sda_oe), .busy_o(busy), .wiper_o(wiper)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of wipers and busy against the model (R4, R6), open-drain timing (R10).
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            logic [NP*8-1:0] exp_w;
            for (int p = 0; p < NP; p++) exp_w[p*8 +: 8] = m_wiper[p];
            check("R4", "wiper outputs", 32'(wiper), 32'(exp_w));
            if (!busy_win) check("R5", "busy idle", 32'(busy), 32'd0);
        end
        if (busy) busy_cycles++;
        scl_hi = scl ? scl_hi + 1 : 0;
        if (rst_n && scl_hi >= 6 && sda_oe !== prev_oe)
            check("R10", "sda_oe changed while SCL high", 32'(sda_oe), 32'(prev_oe));
        prev_oe = sda_oe;
    end

    task automatic hold(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start(); sda_drv = 1; hold(); scl = 1; hold(); sda_drv = 0; hold(); scl = 0; hold(); endtask
    task automatic bus_stop(); sda_drv = 0; hold(); scl = 1; hold(); sda_drv = 1; hold(); endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; hold(); scl = 1; hold(); scl = 0; hold();
        end
        sda_drv = 1; hold(); scl = 1;
        repeat (Q/2) @(negedge clk);
        acked = sda_oe;
        repeat (Q/2) @(negedge clk);
        scl = 0; hold();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        for (int i = 7; i >= 0; i--) begin
            hold(); scl = 1;
            repeat (Q/2) @(negedge clk);
            b[i] = sda_line;
            repeat (Q/2) @(negedge clk);
            scl = 0;
        end
        hold(); sda_drv = !m_ack; hold(); scl = 1; hold(); scl = 0;
        repeat (2) @(negedge clk);
        sda_drv = 1;
    endtask

    task automatic send_expect(input string req, input string what, input logic [7:0] b, input logic exp_ack);
        logic a;
        send_byte(b, a);
        check(req, what, 32'(a), 32'(exp_ack));
    endtask

    task automatic read_reg(input string req, input logic [7:0] instr, input logic [7:0] exp);
        logic [7:0] v;
        bus_start();
        send_expect(req, "read address ack", ADR, 1);
        send_expect(req, "read instr ack", instr, 1);
        recv_byte(v, 0);
        check(req, "read value", 32'(v), 32'(exp));
        bus_stop();
    endtask

    initial begin
        for (int p = 0; p < NP; p++) m_wiper[p] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (10) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "sda_oe after reset", 32'(sda_oe), 32'd0);
        check("R1", "busy after reset", 32'(busy), 32'd0);
        check("R1", "wipers after reset", 32'(wiper), 32'd0);
        mon_en = 1;

        // R2 R3 R4: wiper write on pot 0
        bus_start();
        send_expect("R2", "matching address", ADR, 1);
        send_expect("R3", "write wiper instr", 8'hB0, 1);
        mon_en = 0;
        send_expect("R4", "wiper data ack", 8'hA5, 1);
        m_wiper[0] = 8'hA5; mon_en = 1;
        bus_stop(); repeat (20) @(negedge clk);
        check("R4", "no busy after wiper write", 32'(busy), 32'd0);

        // R2: wrong prefix, then wrong strap bits
        bus_start();
        send_expect("R2", "wrong prefix", 8'h6A, 0);
        send_expect("R2", "after wrong prefix", 8'hB0, 0);
        send_expect("R2", "data after wrong prefix", 8'hFF, 0);
        bus_stop();
        bus_start();
        send_expect("R2", "wrong strap", 8'h5B, 0);
        send_expect("R2", "after wrong strap", 8'hB1, 0);
        bus_stop();

        // R3: unknown opcode and pot out of range
        bus_start();
        send_expect("R3", "address before bad opcode", ADR, 1);
        send_expect("R3", "bad opcode", 8'h00, 0);
        send_expect("R3", "data after bad opcode", 8'h12, 0);
        bus_stop();
        bus_start();
        send_expect("R3", "address before bad pot", ADR, 1);
        send_expect("R3", "pot select 3", 8'hB3, 0);
        bus_stop();

        // R5 R6: data register write pot 1 reg 2, commit at STOP, busy window
        busy_cycles = 0;
        bus_start();
        send_expect("R5", "address", ADR, 1);
        send_expect("R5", "write data instr", 8'hC9, 1);
        send_expect("R5", "data byte", 8'h3C, 1);
        busy_win = 1;
        bus_stop();
        check("R5", "busy after STOP", 32'(busy), 32'd1);
        bus_start();
        send_expect("R6", "address while busy", ADR, 0);
        bus_stop();
        for (int i = 0; i < 4 * PROG && busy; i++) @(negedge clk);
        check("R5", "busy length", 32'(busy_cycles), 32'(PROG));
        busy_win = 0;

        // R8: read with master ack, then nack, then released line
        begin
            logic [7:0] v;
            bus_start();
            send_expect("R8", "address", ADR, 1);
            send_expect("R8", "read data instr", 8'h99, 1);
            recv_byte(v, 1); check("R8", "first byte", 32'(v), 32'h3C);
            recv_byte(v, 0); check("R8", "repeat after ack", 32'(v), 32'h3C);
            recv_byte(v, 0); check("R8", "released after nack", 32'(v), 32'hFF);
            bus_stop();
        end
        read_reg("R8", 8'hA0, 8'hA5);
        read_reg("R1", 8'h90, 8'h00);

        // R7: held data write dropped by repeated START
        busy_cycles = 0;
        bus_start();
        send_expect("R7", "address", ADR, 1);
        send_expect("R7", "write data instr", 8'hCC, 1);
        send_expect("R7", "data byte", 8'h77, 1);
        bus_start();
        send_expect("R7", "address after restart", ADR, 1);
        send_expect("R7", "read back instr", 8'h9C, 1);
        begin
            logic [7:0] v;
            recv_byte(v, 0); check("R7", "discarded write", 32'(v), 32'h00);
        end
        bus_stop(); repeat (20) @(negedge clk);
        check("R7", "no busy after dropped write", 32'(busy_cycles), 32'd0);
        check("R7", "sda released after STOP", 32'(sda_oe), 32'd0);

        // R7: partial data byte then STOP
        bus_start();
        send_expect("R7", "address", ADR, 1);
        send_expect("R7", "wiper instr", 8'hB1, 1);
        for (int i = 0; i < 4; i++) begin
            sda_drv = i[0]; hold(); scl = 1; hold(); scl = 0; hold();
        end
        bus_stop(); repeat (20) @(negedge clk);
        check("R7", "wiper 1 after partial byte", 32'(wiper[15:8]), 32'h00);

        // R9: extra byte after data is not acknowledged
        bus_start();
        send_expect("R9", "address", ADR, 1);
        send_expect("R9", "wiper instr", 8'hB1, 1);
        mon_en = 0;
        send_expect("R9", "first data", 8'h11, 1);
        m_wiper[1] = 8'h11; mon_en = 1;
        send_expect("R9", "extra data", 8'h22, 0);
        bus_stop(); repeat (20) @(negedge clk);
        check("R9", "wiper 1 keeps first byte", 32'(wiper[15:8]), 32'h11);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule